// File: doc/BRIEF.md
# Resource-Interlocked Multithread Issue Scheduler

This block decides, every clock cycle, which of up to four hardware threads may issue its next instruction. Each thread offers a valid flag, an 8-bit mask of the execution resources its pending instruction needs, and a 2-bit priority. The block compares each need mask against a shared availability vector to find the threads whose needs are fully met. Among those threads it grants exactly one.

The pick goes to the highest priority present among the eligible threads. Ties at that level go round-robin, starting from the thread after the one granted last. The grant is combinational and appears in the same cycle as the inputs that cause it. Along with the grant, the block reports the granted thread's need mask as the set of resources that become busy. A thread may claim every resource, or different threads may use disjoint sets in different cycles. Instruction decode and the execution units are outside this block.

Top module: `thread_issue_sched`

## Requirements
- R1: A thread is eligible only when its valid bit is 1 and every bit set in its need mask is also set in `resAvail`. A thread whose need includes an unavailable resource is never granted.
- R2: When no thread is eligible, `grantValid` is 0, `grantOneHot` is 0, `grantIdx` is 0 and `busyMask` is 0. The round-robin pointer keeps its value.
- R3: The grant goes to an eligible thread with the numerically largest priority. Priority 3 is the highest and 0 the lowest. Thread i's priority is `threadPrio[2*i+1:2*i]`.
- R4: Among eligible threads at that top priority, the winner is the first one found by searching upward from the last granted thread plus one, wrapping modulo the thread count.
- R5: `grantOneHot` has at most one bit set. Bit i means thread i was granted. `grantIdx` equals that index, and `grantValid` equals the OR of `grantOneHot`.
- R6: While a grant is given, `busyMask` equals the granted thread's need mask in that same cycle. Thread i's mask is `threadNeed[8*i+7:8*i]`. A single thread needing all eight resources gets `busyMask` = 8'hFF.
- R7: Reset sets the pointer to the last thread. During reset, with all inputs idle, every output is 0. The first tie after reset goes to thread 0.
- R8: A valid thread whose need mask is zero is eligible whatever `resAvail` holds.
- R9: A thread whose valid bit is 0 is never granted, whatever its priority and need.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadValid | input | 4 | Per-thread pending-instruction flag |
| threadNeed | input | 32 | Per-thread resource need masks, 8 bits per thread |
| threadPrio | input | 8 | Per-thread priorities, 2 bits per thread |
| resAvail | input | 8 | Resources currently free |
| grantValid | output | 1 | A thread is granted this cycle |
| grantOneHot | output | 4 | One-hot granted thread |
| grantIdx | output | 2 | Index of the granted thread |
| busyMask | output | 8 | Resources claimed by the grant |

## Verification
The hardest state to reach is one where the round-robin pointer matters. This needs a tie at the top priority, while a higher-priority thread is blocked only by a missing resource and the pointer has just held across an idle cycle. Directed sequences build this up step by step. They first grant a chosen thread to place the pointer, then apply a cycle in which every valid thread is blocked, then present a tie beside a blocked higher-priority thread. After that, a long pseudo-random run of masks and priorities is compared against a reference model of the arbitration that runs inside the bench.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;
  localparam int MAX_THREADS = 4;
  localparam int SLOT_W = $clog2(MAX_THREADS);

  // control-to-datapath strobes
  typedef struct packed {
    logic              fire;
    logic [SLOT_W-1:0] slot;
  } issueStrobe_t;
endpackage

// File: rtl/issue_arb_ctrl.sv
module issue_arb_ctrl
  import issue_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PRIO_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        eligible,
  input  logic [NUM_THREADS*PRIO_W-1:0] prioFlat,
  input  logic [SLOT_W-1:0]             lastSlot,
  output issueStrobe_t                  strobe
);
  logic [PRIO_W-1:0] prio [NUM_THREADS];
  logic [PRIO_W-1:0] bestPrio;
  logic [SLOT_W-1:0] pick;
  logic              found;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_unpack
    assign prio[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  // top priority among eligible threads
  always_comb begin
    bestPrio = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (eligible[i] && prio[i] > bestPrio) bestPrio = prio[i];
    end
  end

  // rotating search starting after last winner
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      logic [SLOT_W-1:0] cand;
      cand = SLOT_W'((int'(lastSlot) + k) % NUM_THREADS);
      if (!found && eligible[cand] && prio[cand] == bestPrio) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  assign strobe.fire = found;
  assign strobe.slot = pick;

  // independent check: nobody eligible outranks the winner
  logic outranked;
  always_comb begin
    outranked = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (eligible[i] && prio[i] > prio[strobe.slot]) outranked = 1'b1;
    end
  end

  p_idle_no_fire_r2: assert property (@(posedge clk) disable iff (!rstN)
    (eligible == '0) |-> !strobe.fire);
  p_pick_eligible_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> eligible[strobe.slot]);
  p_top_prio_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> !outranked);
  p_some_fire_r4: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |-> strobe.fire);
endmodule

// File: rtl/issue_elig_dp.sv
module issue_elig_dp
  import issue_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int RES_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_THREADS-1:0]       threadValid,
  input  logic [NUM_THREADS*RES_W-1:0] needFlat,
  input  logic [RES_W-1:0]             resAvail,
  input  issueStrobe_t                 strobe,
  output logic [NUM_THREADS-1:0]       eligible,
  output logic [SLOT_W-1:0]            lastSlot,
  output logic                         grantValid,
  output logic [NUM_THREADS-1:0]       grantOneHot,
  output logic [SLOT_W-1:0]            grantIdx,
  output logic [RES_W-1:0]             busyMask
);
  localparam logic [SLOT_W-1:0] RESET_SLOT = SLOT_W'(NUM_THREADS - 1);

  logic [RES_W-1:0] need [NUM_THREADS];

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thread
    assign need[g]        = needFlat[g*RES_W +: RES_W];
    assign eligible[g]    = threadValid[g] && ((need[g] & ~resAvail) == '0);
    assign grantOneHot[g] = strobe.fire && (strobe.slot == SLOT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN)            lastSlot <= RESET_SLOT;
    else if (strobe.fire) lastSlot <= strobe.slot;
  end

  assign grantValid = strobe.fire;
  assign grantIdx   = strobe.fire ? strobe.slot : '0;
  assign busyMask   = strobe.fire ? need[strobe.slot] : '0;

  p_busy_was_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((busyMask & ~resAvail) == '0));
  p_valid_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> threadValid[grantIdx]);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot) && (grantValid == (grantOneHot != '0)));
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |=> $stable(lastSlot));
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import issue_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int RES_W = 8,
  parameter int PRIO_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        threadValid,
  input  logic [NUM_THREADS*RES_W-1:0]  threadNeed,
  input  logic [NUM_THREADS*PRIO_W-1:0] threadPrio,
  input  logic [RES_W-1:0]              resAvail,
  output logic                          grantValid,
  output logic [NUM_THREADS-1:0]        grantOneHot,
  output logic [SLOT_W-1:0]             grantIdx,
  output logic [RES_W-1:0]              busyMask
);
  issueStrobe_t           strobe;
  logic [NUM_THREADS-1:0] eligible;
  logic [SLOT_W-1:0]      lastSlot;

  issue_arb_ctrl #(.NUM_THREADS(NUM_THREADS), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .prioFlat(threadPrio),
    .lastSlot(lastSlot), .strobe(strobe)
  );

  issue_elig_dp #(.NUM_THREADS(NUM_THREADS), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .threadValid(threadValid), .needFlat(threadNeed),
    .resAvail(resAvail), .strobe(strobe), .eligible(eligible),
    .lastSlot(lastSlot), .grantValid(grantValid), .grantOneHot(grantOneHot),
    .grantIdx(grantIdx), .busyMask(busyMask)
  );
endmodule

// File: tb/thread_issue_sched_test.sv
module thread_issue_sched_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  threadValid = '0;
  logic [31:0] threadNeed = '0;
  logic [7:0]  threadPrio = '0;
  logic [7:0]  resAvail = '0;
  logic        grantValid;
  logic [3:0]  grantOneHot;
  logic [1:0]  grantIdx;
  logic [7:0]  busyMask;

  int testsRun = 0;
  int testsFailed = 0;
  int modelPtr = 3;

  typedef struct {
    string      req;
    logic       gv;
    logic [3:0] oh;
    logic [1:0] idx;
    logic [7:0] busy;
  } expItem_t;

  expItem_t expQ[$];

  thread_issue_sched uut (
    .clk(clk), .rstN(rstN), .threadValid(threadValid), .threadNeed(threadNeed),
    .threadPrio(threadPrio), .resAvail(resAvail), .grantValid(grantValid),
    .grantOneHot(grantOneHot), .grantIdx(grantIdx), .busyMask(busyMask)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic compareNow(expItem_t e);
    testsRun++;
    if (grantValid !== e.gv || grantOneHot !== e.oh || grantIdx !== e.idx || busyMask !== e.busy) begin
      testsFailed++;
      $display("FAIL %s: got v=%b oh=%b idx=%0d busy=%h, expected v=%b oh=%b idx=%0d busy=%h",
               e.req, grantValid, grantOneHot, grantIdx, busyMask, e.gv, e.oh, e.idx, e.busy);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) compareNow(expQ.pop_front());
    end
  end

  // driver: apply stimulus, predict, push expectation
  task automatic drive(string req, logic [3:0] v, logic [31:0] need,
                       logic [7:0] prio, logic [7:0] avail);
    expItem_t e;
    @(posedge clk);
    #1;
    threadValid = v; threadNeed = need; threadPrio = prio; resAvail = avail;
    e.req = req; e.gv = 1'b0; e.oh = '0; e.idx = '0; e.busy = '0;
    for (int p = 3; p >= 0 && !e.gv; p--) begin
      for (int k = 1; k <= 4 && !e.gv; k++) begin
        int t;
        t = (modelPtr + k) % 4;
        if (v[t] && ((need[8*t +: 8] & ~avail) == 8'h00) && int'(prio[2*t +: 2]) == p) begin
          e.gv = 1'b1; e.idx = 2'(t); e.oh = 4'(1 << t); e.busy = need[8*t +: 8];
        end
      end
    end
    expQ.push_back(e);
    if (e.gv) modelPtr = int'(e.idx);
  endtask

  initial begin
    #(PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    expItem_t z;
    logic [31:0] lfsr;
    z.req = "R7"; z.gv = 0; z.oh = '0; z.idx = '0; z.busy = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareNow(z);               // R7: outputs idle in reset
    @(posedge clk); #1 rstN = 1'b1;

    // R7/R8: first tie after reset goes to thread 0, zero needs always eligible
    drive("R7", 4'hF, 32'h0, 8'h00, 8'h00);
    // R4: rotating ties
    drive("R4", 4'hF, 32'h0, 8'h00, 8'h00);
    drive("R4", 4'hF, 32'h0, 8'h00, 8'h00);
    drive("R4", 4'hF, 32'h0, 8'h00, 8'h00);
    drive("R4", 4'hF, 32'h0, 8'h00, 8'h00);
    // R2: every thread blocked, pointer holds (last=0)
    drive("R2", 4'hF, 32'h01010101, 8'hFF, 8'h00);
    drive("R4", 4'hF, 32'h0, 8'h00, 8'h00);  // expect thread 1
    // R1: thread 2 blocked by bit 3, then freed
    drive("R1", 4'h4, 32'h00080000, 8'h00, 8'hF7);
    drive("R1", 4'h4, 32'h00080000, 8'h00, 8'h08);
    // R3: highest eligible priority wins
    drive("R3", 4'hA, 32'h0, 8'hC4, 8'h00);
    // R3/R1: higher priority blocked, lower eligible wins
    drive("R3", 4'hA, 32'h10000000, 8'hC4, 8'h00);
    // R4: tie at top with blocked higher thread, after idle cycle
    drive("R2", 4'hF, 32'hFFFFFFFF, 8'h00, 8'h00);
    drive("R4", 4'hF, 32'h80000000, 8'hD5, 8'h7F);
    // R9: invalid high-priority thread ignored
    drive("R9", 4'h1, 32'h0, 8'hFC, 8'hFF);
    drive("R9", 4'h0, 32'h0, 8'hFF, 8'hFF);
    // R6: single thread claims all resources
    drive("R6", 4'h2, 32'h0000FF00, 8'h00, 8'hFF);
    drive("R6", 4'hF, 32'h03300C81, 8'h1B, 8'hFF);
    // R5: pseudo-random sweep
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr * 32'h9E3779B1;
      b = a ^ (a >> 13);
      drive("R5", a[3:0], b & (a << 3), a[15:8], b[23:16] | a[31:24]);
    end
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule